// File: doc/BRIEF.md
# Playback Test Waveform Generator

This block produces synthetic ADC sample streams so the downstream trigger and readout logic can be exercised without any external detector signal. It drives two groups of eight channels, a scintillator group and a calorimeter group, and emits one 12-bit sample per channel per clock. One clock is one 4 ns sample tick. Each play is a fixed window of 32 samples. Every sample equals the group pedestal, except inside a rectangular pulse. The pulse begins at the group's programmed delay and lasts the group's programmed width. Inside the pulse, a channel adds its amplitude to the pedestal. The amplitude is one 4-bit field of a packed 32-bit amplitude word, multiplied by 100.

Software programs the pedestals, widths, delays, amplitude words and a trigger count, then pulses `start`. The generator captures the whole configuration at that moment. It then plays the window once per internal trigger, raising a trigger strobe on the first sample of each play. Consecutive plays are separated by 32 idle ticks. A done flag rises when the last play has finished. A configuration whose pulse would run past the end of the window, or whose trigger count is too large, is refused: an error flag is raised and nothing plays.

Top module: `playback_wavegen`

## Requirements
- R1: After reset, `sampleValid`, `trigStrobe`, `busy`, `done` and `cfgError` are 0 and both sample buses are 0.
- R2: A `start` with `trigCount` equal to 0 plays nothing and leaves `busy`, `done` and `cfgError` at 0.
- R3: A `start` with a valid configuration and `trigCount` N (1 to 9) yields N plays. The first sample appears in the cycle after the `start` edge. Each play holds `sampleValid` high for 32 consecutive cycles. `trigStrobe` is high only on the first sample of each play. The last sample of one play and the first sample of the next are separated by exactly 32 cycles with `sampleValid` low.
- R4: At sample index i of a play (0 to 31), channel k of a group equals the group pedestal plus 100 × the amplitude field in bits [4k+3:4k] of the group amplitude word when delay ≤ i < delay + width, and equals the pedestal otherwise. Channel k sits at bits [12k+11:12k] of its sample bus. In the scintillator group, channels 0–3 are the left counters and 4–7 are the right counters.
- R5: A sample whose sum exceeds 4095 is output as 4095.
- R6: The top amplitude field (bits [31:28]) is limited to 7. A stored value of 8 to 15 plays as 7.
- R7: The scintillator and calorimeter groups use their own pedestal, width, delay and amplitude word, independently of each other.
- R8: A `start` with `trigCount` of 10 or more, or with width + delay ≥ 32 in either group, sets `cfgError` from the next cycle on. No sample is produced, and `busy` stays 0.
- R9: `done` rises in the cycle after the last sample of the last play and stays high until the next accepted `start`. `busy` is high from the first sample to the last sample.
- R10: A `start` while `busy` is high is ignored. The running sequence keeps its count and its timing.
- R11: Both sample buses are 0 whenever `sampleValid` is 0.
- R12: The configuration is captured at the accepted `start`. Input changes during a run do not alter the samples of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per sample |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| trigCount | input | 4 | Number of plays; 0 disables playback |
| scintPed | input | 12 | Scintillator pedestal |
| scintWidth | input | 5 | Scintillator pulse width in samples |
| scintDelay | input | 5 | Scintillator pulse start index |
| scintAmp | input | 32 | Scintillator amplitude word, 4 bits per channel |
| calPed | input | 12 | Calorimeter pedestal |
| calWidth | input | 5 | Calorimeter pulse width in samples |
| calDelay | input | 5 | Calorimeter pulse start index |
| calAmp | input | 32 | Calorimeter amplitude word, 4 bits per channel |
| scintSamples | output | 96 | Eight 12-bit scintillator samples |
| calSamples | output | 96 | Eight 12-bit calorimeter samples |
| sampleValid | output | 1 | Samples valid this cycle |
| trigStrobe | output | 1 | First sample of a play |
| busy | output | 1 | A play sequence is in progress |
| done | output | 1 | Last play of the sequence has completed |
| cfgError | output | 1 | Last start was refused |

## Verification
A wrong sample index or a wrong pulse boundary shows up at once on the sample buses, in the first cycle where that index is inside or at the edge of the window. The sweep therefore covers every width and delay pair that fits. A wrong play counter or gap counter only appears at the edge of a play: an extra or missing trigger strobe, a gap of the wrong length, or `done` rising early or late. That can be up to about 600 cycles after the start. A stale or mis-captured configuration shows up in the next play of a sequence whose inputs change mid-run.

// File: rtl/playback_wavegen_pkg.sv
package playback_wavegen_pkg;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_PLAY = 2'd1,
    PB_GAP  = 2'd2
  } pbState_e;

  typedef struct packed {
    logic loadCfg;
    logic active;
  } pbStrobes_t;

endpackage

// File: rtl/pbgen_group.sv
module pbgen_group #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 12,
  parameter int NIB_W    = 4,
  parameter int IDX_W    = 5,
  parameter int WIN_LEN  = 32,
  parameter int AMP_STEP = 100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadCfg,
  input  logic                       active,
  input  logic [IDX_W-1:0]           idx,
  input  logic [SAMPLE_W-1:0]        pedIn,
  input  logic [IDX_W-1:0]           widthIn,
  input  logic [IDX_W-1:0]           delayIn,
  input  logic [NUM_CH*NIB_W-1:0]    ampIn,
  output logic                       cfgOk,
  output logic [NUM_CH*SAMPLE_W-1:0] samples
);
  localparam int SIG_W   = NUM_CH * NIB_W;
  localparam int SUM_W   = SAMPLE_W + 1;
  localparam int TOP_CAP = (1 << (NIB_W - 1)) - 1;
  localparam logic [SAMPLE_W-1:0] SAT_MAX = {SAMPLE_W{1'b1}};

  logic [SAMPLE_W-1:0] pedReg;
  logic [IDX_W-1:0]    widthReg;
  logic [IDX_W-1:0]    delayReg;
  logic [SIG_W-1:0]    ampReg;
  logic [SIG_W-1:0]    ampClamped;
  logic                inPulse;

  // window fit check on the raw inputs, used by control at start
  assign cfgOk = ({1'b0, widthIn} + {1'b0, delayIn}) < (IDX_W+1)'(WIN_LEN);

  always_comb begin
    ampClamped = ampIn;
    if (ampIn[SIG_W-1]) ampClamped[SIG_W-1 -: NIB_W] = NIB_W'(TOP_CAP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pedReg   <= '0;
      widthReg <= '0;
      delayReg <= '0;
      ampReg   <= '0;
    end else if (loadCfg) begin
      pedReg   <= pedIn;
      widthReg <= widthIn;
      delayReg <= delayIn;
      ampReg   <= ampClamped;
    end
  end

  assign inPulse = ({1'b0, idx} >= {1'b0, delayReg}) &&
                   ({1'b0, idx} < ({1'b0, delayReg} + {1'b0, widthReg}));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [NIB_W-1:0] chNib;
    logic [SUM_W-1:0] chAmp;
    logic [SUM_W-1:0] chSum;
    assign chNib = ampReg[k*NIB_W +: NIB_W];
    assign chAmp = inPulse ? (SUM_W'(chNib) * SUM_W'(AMP_STEP)) : '0;
    assign chSum = {1'b0, pedReg} + chAmp;
    assign samples[k*SAMPLE_W +: SAMPLE_W] =
      !active ? '0 : (chSum[SUM_W-1] ? SAT_MAX : chSum[SAMPLE_W-1:0]);
  end
endmodule

// File: rtl/pbgen_datapath.sv
module pbgen_datapath #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 12,
  parameter int NIB_W    = 4,
  parameter int IDX_W    = 5,
  parameter int WIN_LEN  = 32,
  parameter int AMP_STEP = 100
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  playback_wavegen_pkg::pbStrobes_t        strobes,
  input  logic [IDX_W-1:0]                        idx,
  input  logic [SAMPLE_W-1:0]                     scintPed,
  input  logic [IDX_W-1:0]                        scintWidth,
  input  logic [IDX_W-1:0]                        scintDelay,
  input  logic [NUM_CH*NIB_W-1:0]                 scintAmp,
  input  logic [SAMPLE_W-1:0]                     calPed,
  input  logic [IDX_W-1:0]                        calWidth,
  input  logic [IDX_W-1:0]                        calDelay,
  input  logic [NUM_CH*NIB_W-1:0]                 calAmp,
  output logic                                    cfgOk,
  output logic [NUM_CH*SAMPLE_W-1:0]              scintSamples,
  output logic [NUM_CH*SAMPLE_W-1:0]              calSamples
);
  logic scintOk;
  logic calOk;

  pbgen_group #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NIB_W(NIB_W),
    .IDX_W(IDX_W), .WIN_LEN(WIN_LEN), .AMP_STEP(AMP_STEP)
  ) scintGrp_i (
    .clk(clk), .rstN(rstN),
    .loadCfg(strobes.loadCfg), .active(strobes.active), .idx(idx),
    .pedIn(scintPed), .widthIn(scintWidth), .delayIn(scintDelay),
    .ampIn(scintAmp), .cfgOk(scintOk), .samples(scintSamples)
  );

  pbgen_group #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NIB_W(NIB_W),
    .IDX_W(IDX_W), .WIN_LEN(WIN_LEN), .AMP_STEP(AMP_STEP)
  ) calGrp_i (
    .clk(clk), .rstN(rstN),
    .loadCfg(strobes.loadCfg), .active(strobes.active), .idx(idx),
    .pedIn(calPed), .widthIn(calWidth), .delayIn(calDelay),
    .ampIn(calAmp), .cfgOk(calOk), .samples(calSamples)
  );

  assign cfgOk = scintOk && calOk;
endmodule

// File: rtl/pbgen_ctrl.sv
module pbgen_ctrl #(
  parameter int IDX_W    = 5,
  parameter int WIN_LEN  = 32,
  parameter int GAP_LEN  = 32,
  parameter int MAX_TRIG = 9,
  parameter int MODE_W   = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic [MODE_W-1:0]                  trigCount,
  input  logic                               cfgOk,
  output playback_wavegen_pkg::pbStrobes_t   strobes,
  output logic [IDX_W-1:0]                   idx,
  output logic                               sampleValid,
  output logic                               trigStrobe,
  output logic                               busy,
  output logic                               done,
  output logic                               cfgError
);
  import playback_wavegen_pkg::*;

  localparam int GAP_W = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;

  pbState_e          state;
  logic [GAP_W-1:0]  gapCnt;
  logic [MODE_W-1:0] playCnt;
  logic [MODE_W-1:0] trigTotal;
  logic              lastIdx;
  logic              lastPlay;

  assign lastIdx  = (idx == IDX_W'(WIN_LEN - 1));
  assign lastPlay = (MODE_W'(playCnt + 1'b1) == trigTotal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PB_IDLE;
      idx       <= '0;
      gapCnt    <= '0;
      playCnt   <= '0;
      trigTotal <= '0;
      done      <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      case (state)
        PB_IDLE: begin
          if (start) begin
            done     <= 1'b0;
            cfgError <= 1'b0;
            if (trigCount != '0) begin
              if ((trigCount > MODE_W'(MAX_TRIG)) || !cfgOk) begin
                cfgError <= 1'b1;
              end else begin
                state     <= PB_PLAY;
                idx       <= '0;
                playCnt   <= '0;
                trigTotal <= trigCount;
              end
            end
          end
        end
        PB_PLAY: begin
          idx <= idx + 1'b1;
          if (lastIdx) begin
            idx <= '0;
            if (lastPlay) begin
              state <= PB_IDLE;
              done  <= 1'b1;
            end else begin
              state  <= PB_GAP;
              gapCnt <= '0;
            end
          end
        end
        PB_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == GAP_W'(GAP_LEN - 1)) begin
            state   <= PB_PLAY;
            idx     <= '0;
            playCnt <= playCnt + 1'b1;
          end
        end
        default: state <= PB_IDLE;
      endcase
    end
  end

  assign strobes.loadCfg = (state == PB_IDLE) && start;
  assign strobes.active  = (state == PB_PLAY);
  assign sampleValid     = (state == PB_PLAY);
  assign trigStrobe      = (state == PB_PLAY) && (idx == '0);
  assign busy            = (state != PB_IDLE);
endmodule

// File: rtl/playback_wavegen.sv
module playback_wavegen #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 12,
  parameter int NIB_W    = 4,
  parameter int WIN_LEN  = 32,
  parameter int GAP_LEN  = 32,
  parameter int MAX_TRIG = 9,
  parameter int AMP_STEP = 100,
  localparam int IDX_W   = $clog2(WIN_LEN),
  localparam int MODE_W  = $clog2(MAX_TRIG + 1),
  localparam int SIG_W   = NUM_CH * NIB_W,
  localparam int BUS_W   = NUM_CH * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [MODE_W-1:0]   trigCount,
  input  logic [SAMPLE_W-1:0] scintPed,
  input  logic [IDX_W-1:0]    scintWidth,
  input  logic [IDX_W-1:0]    scintDelay,
  input  logic [SIG_W-1:0]    scintAmp,
  input  logic [SAMPLE_W-1:0] calPed,
  input  logic [IDX_W-1:0]    calWidth,
  input  logic [IDX_W-1:0]    calDelay,
  input  logic [SIG_W-1:0]    calAmp,
  output logic [BUS_W-1:0]    scintSamples,
  output logic [BUS_W-1:0]    calSamples,
  output logic                sampleValid,
  output logic                trigStrobe,
  output logic                busy,
  output logic                done,
  output logic                cfgError
);
  playback_wavegen_pkg::pbStrobes_t strobes;
  logic [IDX_W-1:0] idx;
  logic             cfgOk;

  pbgen_ctrl #(
    .IDX_W(IDX_W), .WIN_LEN(WIN_LEN), .GAP_LEN(GAP_LEN),
    .MAX_TRIG(MAX_TRIG), .MODE_W(MODE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .trigCount(trigCount),
    .cfgOk(cfgOk), .strobes(strobes), .idx(idx),
    .sampleValid(sampleValid), .trigStrobe(trigStrobe), .busy(busy),
    .done(done), .cfgError(cfgError)
  );

  pbgen_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NIB_W(NIB_W),
    .IDX_W(IDX_W), .WIN_LEN(WIN_LEN), .AMP_STEP(AMP_STEP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(idx),
    .scintPed(scintPed), .scintWidth(scintWidth), .scintDelay(scintDelay),
    .scintAmp(scintAmp), .calPed(calPed), .calWidth(calWidth),
    .calDelay(calDelay), .calAmp(calAmp), .cfgOk(cfgOk),
    .scintSamples(scintSamples), .calSamples(calSamples)
  );
endmodule

// File: rtl/playback_wavegen_chk.sv
module playback_wavegen_chk #(
  parameter int BUS_W = 96
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [BUS_W-1:0] scintSamples,
  input logic [BUS_W-1:0] calSamples,
  input logic             sampleValid,
  input logic             trigStrobe,
  input logic             busy,
  input logic             done,
  input logic             cfgError
);
  a_r3_strobe_in_play: assert property (@(posedge clk) disable iff (!rstN)
    trigStrobe |-> sampleValid);

  a_r3_play_opens_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleValid) |-> trigStrobe);

  a_r3_no_hole_in_play: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !trigStrobe) |-> $past(sampleValid));

  a_r11_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ((scintSamples == '0) && (calSamples == '0)));

  a_r8_error_blocks_play: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!busy && !sampleValid));

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_done_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(sampleValid));

  a_r10_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !cfgError);
endmodule

bind playback_wavegen playback_wavegen_chk #(.BUS_W(BUS_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start),
  .scintSamples(scintSamples), .calSamples(calSamples),
  .sampleValid(sampleValid), .trigStrobe(trigStrobe), .busy(busy),
  .done(done), .cfgError(cfgError)
);

// File: tb/playback_wavegen_tb_top.sv
module playback_wavegen_tb_top;
  localparam int CLK_PERIOD = 4;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  trigCount = '0;
  logic [11:0] scintPed = '0, calPed = '0;
  logic [4:0]  scintWidth = '0, scintDelay = '0, calWidth = '0, calDelay = '0;
  logic [31:0] scintAmp = '0, calAmp = '0;
  logic [95:0] scintSamples, calSamples;
  logic        sampleValid, trigStrobe, busy, done, cfgError;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // model copies of the configuration captured at start
  int mSPed, mSW, mSD, mCPed, mCW, mCD;
  logic [31:0] mSAmp, mCAmp;

  always #(CLK_PERIOD/2) clk = ~clk;

  playback_wavegen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .trigCount(trigCount),
    .scintPed(scintPed), .scintWidth(scintWidth), .scintDelay(scintDelay),
    .scintAmp(scintAmp), .calPed(calPed), .calWidth(calWidth),
    .calDelay(calDelay), .calAmp(calAmp),
    .scintSamples(scintSamples), .calSamples(calSamples),
    .sampleValid(sampleValid), .trigStrobe(trigStrobe), .busy(busy),
    .done(done), .cfgError(cfgError)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG_LIMIT) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [95:0] expGroup(int ped, int w, int d, logic [31:0] amp,
                                           int idx, bit valid);
    logic [95:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      int nib = int'(amp[k*4 +: 4]);
      int s = ped;
      if (k == 7 && nib > 7) nib = 7;
      if (idx >= d && idx < d + w) s = s + nib * 100;
      if (s > 4095) s = 4095;
      if (valid) v[k*12 +: 12] = 12'(s);
    end
    return v;
  endfunction

  task automatic checkVec(string tag, logic [196:0] act, logic [196:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [196:0] observed();
    return {sampleValid, trigStrobe, busy, done, cfgError, scintSamples, calSamples};
  endfunction

  task automatic setCfg(int sp, int sw, int sd, logic [31:0] sa,
                        int cp, int cw, int cd, logic [31:0] ca);
    scintPed = 12'(sp); scintWidth = 5'(sw); scintDelay = 5'(sd); scintAmp = sa;
    calPed = 12'(cp); calWidth = 5'(cw); calDelay = 5'(cd); calAmp = ca;
    mSPed = sp; mSW = sw; mSD = sd; mSAmp = sa;
    mCPed = cp; mCW = cw; mCD = cd; mCAmp = ca;
  endtask

  // R3 R4 R9: full sequence checked every cycle; disturb covers R10 R12
  task automatic runPlay(int nTrig, bit disturb, string tag);
    int total = (nTrig - 1) * 64 + 32;
    trigCount = 4'(nTrig);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < total; c++) begin
      int  pos = c % 64;
      bit  v = (pos < 32);
      checkVec(tag, observed(),
        {v, v && pos == 0, 1'b1, 1'b0, 1'b0,
         expGroup(mSPed, mSW, mSD, mSAmp, pos, v),
         expGroup(mCPed, mCW, mCD, mCAmp, pos, v)});
      if (disturb && c == 5) begin
        start = 1'b1; trigCount = 4'd1;
        scintPed = 12'd3000; scintWidth = 5'd1; scintDelay = 5'd0;
        scintAmp = 32'h1111_1111; calPed = 12'd7; calAmp = 32'h0;
      end
      if (disturb && c == 6) start = 1'b0;
      if (disturb && c == 70) start = 1'b1;
      if (disturb && c == 71) start = 1'b0;
      @(negedge clk);
    end
    checkVec({tag, " R9 done"}, observed(), {5'b00010, 96'b0, 96'b0});
  endtask

  // R8: refused start
  task automatic runBad(int nTrig, string tag);
    trigCount = 4'(nTrig);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      checkVec(tag, observed(), {5'b00001, 96'b0, 96'b0});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkVec("R1 in reset", observed(), '0);
    rstN = 1'b1;
    @(negedge clk);
    checkVec("R1 after reset", observed(), '0);

    // R2 mode 0 disables playback
    setCfg(200, 5, 1, 32'h000c_000e, 100, 6, 1, 32'h000a_000b);
    trigCount = 4'd0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      checkVec("R2 mode zero", observed(), '0);
      @(negedge clk);
    end

    // R4 R7: sweep every width/delay pair that fits; cal group mirrors it
    for (int w = 0; w < 32; w++) begin
      for (int d = 0; w + d < 32; d++) begin
        setCfg(200 + w, w, d, 32'h7654_3210 ^ {w[3:0], d[3:0], 24'h0}, 100 + d, d, w,
               32'h89ab_cdef ^ {d[3:0], w[3:0], 24'h0});
        runPlay(1, 1'b0, "R4 R7 sweep");
      end
    end

    // R3 R9 multi-play, R5 R6 saturation and top-field cap
    setCfg(4000, 10, 3, 32'hffff_ffff, 3900, 31, 0, 32'h8000_0001);
    runPlay(9, 1'b0, "R3 R5 R6 nine plays saturate");
    setCfg(10, 4, 20, 32'hc000_00f1, 0, 1, 30, 32'h9abc_def0);
    runPlay(2, 1'b0, "R3 R6 two plays");

    // R10 R12 start and input changes mid-run are ignored
    setCfg(300, 7, 8, 32'h2468_ace1, 50, 12, 19, 32'h1357_9bdf);
    runPlay(3, 1'b1, "R10 R12 disturbed run");

    // R8 refused configurations
    setCfg(200, 16, 16, 32'h1, 100, 2, 2, 32'h1);
    runBad(1, "R8 scint w+d=32");
    setCfg(200, 2, 2, 32'h1, 100, 31, 1, 32'h1);
    runBad(2, "R8 cal w+d=32");
    setCfg(200, 2, 2, 32'h1, 100, 2, 2, 32'h1);
    runBad(10, "R8 count 10");
    runBad(15, "R8 count 15");
    // valid start after error clears it
    setCfg(1000, 31, 0, 32'h0000_0005, 5, 0, 31, 32'hffff_ffff);
    runPlay(1, 1'b0, "R8 R9 recover after error");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule